// File: doc/BRIEF.md
# Writeback Buffer with Fill Forwarding

This block sits between a cache's miss handling and its memory port. Dirty lines evicted from the cache are pushed into a small FIFO together with their set index and tag. The block drains them one at a time as full-line writes, using a single memory request slot that it shares with line fetches. When a fetch arrives and the memory slot is free, the fetch goes out before any waiting writeback.

Before a fetch goes to memory, the block searches every buffered line for the same index and tag. On a match it returns the newest buffered copy of the line as a fill on the next cycle and issues no memory read. On a miss it issues a read for the line-aligned address. Fill data returned by memory comes back through the same fill output, one cycle after the response. A line that was forwarded stays in the buffer and is still written back in its turn.

Top module: `wb_forward_buffer`

## Requirements
- R1: While reset is asserted, `mem_req_valid` and `fill_valid` are low, `evict_ready` is high and `wb_quiet` is high.
- R2: Accepted evictions leave as write requests (`mem_req_write`=1) in the order they were accepted. Each carries the evicted data, `mem_req_len` equal to the line size in bytes, and the address {tag, index, OFF_W zero bits}.
- R3: When DEPTH lines are buffered, `evict_ready` is low and an eviction offered in that cycle is dropped: it never produces a write request.
- R4: Once raised, `mem_req_valid` stays high with address, direction and write data unchanged until `mem_req_ready` is seen.
- R5: In the cycle after a request is accepted (`mem_req_valid` and `mem_req_ready` both high), `mem_req_valid` is low.
- R6: When the slot is free, a buffer-missing fetch is issued ahead of any buffered writeback.
- R7: A fetch that misses the buffer is accepted only while the memory slot is free. In the following cycle it appears as a read (`mem_req_write`=0) to {tag, index, zero offset} with the full line length.
- R8: A fetch that hits the buffer is accepted even while the memory slot is busy. On the next cycle it produces `fill_valid` with `fill_fwd`=1, the fetch's index and tag, and the buffered data. No memory read is issued for it.
- R9: When several buffered lines match a fetch, the data of the most recently accepted one is forwarded.
- R10: A line that was forwarded is still drained to memory as a write in its FIFO turn.
- R11: A read response (`mem_rsp_valid`=1, `mem_rsp_write`=0) produces, on the next cycle, `fill_valid` with `fill_fwd`=0 and the response's index, tag and data. `fetch_ready` is low during a read-response cycle.
- R12: `wb_quiet` is high only when the buffer is empty, no write is pending on the port, and every accepted write has been acknowledged (`mem_rsp_valid`=1 with `mem_rsp_write`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | Dirty line offered for writeback |
| evict_ready | output | 1 | Buffer can take a line (low when full) |
| evict_idx | input | IDX_W | Set index of evicted line |
| evict_tag | input | TAG_W | Tag of evicted line |
| evict_data | input | LINE_W | Evicted line contents |
| fetch_valid | input | 1 | Miss logic requests a line |
| fetch_ready | output | 1 | Fetch taken (forwarded or issued) |
| fetch_idx | input | IDX_W | Set index of requested line |
| fetch_tag | input | TAG_W | Tag of requested line |
| fill_valid | output | 1 | Fill data available this cycle |
| fill_fwd | output | 1 | 1: fill came from the buffer, 0: from memory |
| fill_idx | output | IDX_W | Set index of filled line |
| fill_tag | output | TAG_W | Tag of filled line |
| fill_data | output | LINE_W | Filled line contents |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1: writeback, 0: line read |
| mem_req_addr | output | ADDR_W | Line-aligned byte address |
| mem_req_len | output | LEN_W | Transfer length in bytes (whole line) |
| mem_req_wdata | output | LINE_W | Writeback data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_write | input | 1 | 1: write acknowledgement, 0: read data |
| mem_rsp_addr | input | ADDR_W | Address of the answered request |
| mem_rsp_data | input | LINE_W | Read data |
| wb_quiet | output | 1 | No writeback buffered, pending or unacknowledged |

## Verification
A corrupted FIFO pointer or count shows up at the port in one of three ways. A write request can go out with the wrong data or in the wrong order, an eviction can be refused one entry too early or too late, or a write can be dropped, which leaves `wb_quiet` stuck low. All of these are visible within one drain of the buffer. A wrong search result shows on the cycle after the fetch is accepted: the fill carries stale data or the wrong `fill_fwd`, or an extra read appears on the port. An arbiter fault shows up in the next slot handover, either as a writeback ahead of a waiting fetch, a request without the idle cycle, or a payload that changes during a stall.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    GNT_IDLE  = 2'd0,
    GNT_FETCH = 2'd1,
    GNT_DRAIN = 2'd2
  } gnt_e;
endpackage

// File: rtl/wbb_store.sv
// Circular buffer of evicted lines with a newest-first associative search.
module wbb_store #(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [LINE_W-1:0] push_data,
  input  logic              pop,
  input  logic [IDX_W-1:0]  look_idx,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              full,
  output logic              empty,
  output logic [IDX_W-1:0]  head_idx,
  output logic [TAG_W-1:0]  head_tag,
  output logic [LINE_W-1:0] head_data,
  output logic              look_hit,
  output logic [LINE_W-1:0] look_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0]  idx_mem  [DEPTH];
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [LINE_W-1:0] data_mem [DEPTH];

  logic [PTR_W-1:0] wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CNT_W-1:0] count, count_d;
  logic             push_en, pop_en;
  logic [DEPTH-1:0] slot_match;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_en = push & ~full;
  assign pop_en  = pop & ~empty;

  assign head_idx  = idx_mem[rd_ptr];
  assign head_tag  = tag_mem[rd_ptr];
  assign head_data = data_mem[rd_ptr];

  always_comb begin
    wr_ptr_d = push_en ? wr_ptr + PTR_W'(1) : wr_ptr;
    rd_ptr_d = pop_en  ? rd_ptr + PTR_W'(1) : rd_ptr;
    count_d  = count + CNT_W'(push_en) - CNT_W'(pop_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  // Datapath storage: no reset, written only on an accepted push.
  always_ff @(posedge clk) begin
    if (push_en) begin
      idx_mem[wr_ptr]  <= push_idx;
      tag_mem[wr_ptr]  <= push_tag;
      data_mem[wr_ptr] <= push_data;
    end
  end

  // Per-slot compare, independent of occupancy.
  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign slot_match[s] = (idx_mem[s] == look_idx) && (tag_mem[s] == look_tag);
  end

  // Walk from oldest to newest occupied slot; the last match wins.
  always_comb begin
    logic [PTR_W-1:0] slot;
    look_hit  = 1'b0;
    look_data = '0;
    for (int age = 0; age < DEPTH; age++) begin
      slot = rd_ptr + PTR_W'(age);
      if ((CNT_W'(age) < count) && slot_match[slot]) begin
        look_hit  = 1'b1;
        look_data = data_mem[slot];
      end
    end
  end
endmodule

// File: rtl/wbb_arb.sv
// Single memory request slot shared by line fetches and writebacks.
module wbb_arb
  import wbb_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int LINE_W     = 64,
  parameter int LEN_W      = 4,
  parameter int LINE_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_want,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              drain_avail,
  input  logic [ADDR_W-1:0] drain_addr,
  input  logic [LINE_W-1:0] drain_data,
  input  logic              mem_req_ready,
  output gnt_e              grant,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LEN_W-1:0]  mem_req_len,
  output logic [LINE_W-1:0] mem_req_wdata
);
  logic              vld_q, vld_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LINE_W-1:0] data_q, data_d;
  logic              load_en;

  // A request leaves the register on the edge it is accepted, so the
  // next grant can only be loaded one cycle later: one idle cycle.
  always_comb begin
    if (vld_q)            grant = GNT_IDLE;
    else if (fetch_want)  grant = GNT_FETCH;
    else if (drain_avail) grant = GNT_DRAIN;
    else                  grant = GNT_IDLE;
  end

  always_comb begin
    load_en = (grant != GNT_IDLE);
    vld_d   = (vld_q & ~mem_req_ready) | load_en;
    wr_d    = (grant == GNT_DRAIN);
    addr_d  = (grant == GNT_DRAIN) ? drain_addr : fetch_addr;
    data_d  = (grant == GNT_DRAIN) ? drain_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      wr_q   <= wr_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign mem_req_valid = vld_q;
  assign mem_req_write = wr_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_len   = LEN_W'(LINE_BYTES);
  assign mem_req_wdata = data_q;
endmodule

// File: rtl/wbb_resp.sv
// Fill output register and outstanding-write tracking.
module wbb_resp #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int OFF_W  = 3,
  parameter int LINE_W = 64,
  parameter int ACK_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fwd_take,
  input  logic [IDX_W-1:0]              fwd_idx,
  input  logic [TAG_W-1:0]              fwd_tag,
  input  logic [LINE_W-1:0]             fwd_data,
  input  logic                          rsp_valid,
  input  logic                          rsp_write,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]  rsp_addr,
  input  logic [LINE_W-1:0]             rsp_data,
  input  logic                          wr_accept,
  output logic                          fill_valid,
  output logic                          fill_fwd,
  output logic [IDX_W-1:0]              fill_idx,
  output logic [TAG_W-1:0]              fill_tag,
  output logic [LINE_W-1:0]             fill_data,
  output logic                          acks_clear
);
  logic              rd_rsp, wr_ack;
  logic              fv_q, fv_d;
  logic              ff_d;
  logic [IDX_W-1:0]  fi_d;
  logic [TAG_W-1:0]  ft_d;
  logic [LINE_W-1:0] fd_d;
  logic [ACK_W-1:0]  owed_q, owed_d;

  assign rd_rsp = rsp_valid & ~rsp_write;
  assign wr_ack = rsp_valid &  rsp_write;

  always_comb begin
    fv_d   = rd_rsp | fwd_take;
    ff_d   = ~rd_rsp;
    fi_d   = rd_rsp ? rsp_addr[OFF_W +: IDX_W] : fwd_idx;
    ft_d   = rd_rsp ? rsp_addr[OFF_W+IDX_W +: TAG_W] : fwd_tag;
    fd_d   = rd_rsp ? rsp_data : fwd_data;
    owed_d = owed_q + ACK_W'(wr_accept) - ACK_W'(wr_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q   <= 1'b0;
      owed_q <= '0;
    end else begin
      fv_q   <= fv_d;
      owed_q <= owed_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fv_d) begin
      fill_fwd  <= ff_d;
      fill_idx  <= fi_d;
      fill_tag  <= ft_d;
      fill_data <= fd_d;
    end
  end

  assign fill_valid = fv_q;
  assign acks_clear = (owed_q == '0);
endmodule

// File: rtl/wb_forward_buffer.sv
module wb_forward_buffer
  import wbb_pkg::*;
#(
  parameter  int IDX_W      = 4,
  parameter  int TAG_W      = 8,
  parameter  int OFF_W      = 3,
  parameter  int DEPTH      = 4,
  parameter  int ACK_W      = 4,
  localparam int LINE_BYTES = 1 << OFF_W,
  localparam int LINE_W     = 8 * LINE_BYTES,
  localparam int ADDR_W     = TAG_W + IDX_W + OFF_W,
  localparam int LEN_W      = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  output logic              evict_ready,
  input  logic [IDX_W-1:0]  evict_idx,
  input  logic [TAG_W-1:0]  evict_tag,
  input  logic [LINE_W-1:0] evict_data,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [IDX_W-1:0]  fetch_idx,
  input  logic [TAG_W-1:0]  fetch_tag,
  output logic              fill_valid,
  output logic              fill_fwd,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [LINE_W-1:0] fill_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LEN_W-1:0]  mem_req_len,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_write,
  input  logic [ADDR_W-1:0] mem_rsp_addr,
  input  logic [LINE_W-1:0] mem_rsp_data,
  output logic              wb_quiet
);
  logic              buf_full, buf_empty;
  logic [IDX_W-1:0]  head_idx;
  logic [TAG_W-1:0]  head_tag;
  logic [LINE_W-1:0] head_data;
  logic              look_hit;
  logic [LINE_W-1:0] look_data;
  logic              rd_rsp_now;
  logic              fetch_want, fwd_take;
  logic              wr_accept, acks_clear;
  gnt_e              grant;
  logic [ADDR_W-1:0] fetch_addr, drain_addr;

  assign rd_rsp_now  = mem_rsp_valid & ~mem_rsp_write;
  assign fetch_want  = fetch_valid & ~look_hit & ~rd_rsp_now;
  assign fwd_take    = fetch_valid &  look_hit & ~rd_rsp_now;
  assign fetch_ready = fwd_take | (grant == GNT_FETCH);
  assign evict_ready = ~buf_full;
  assign fetch_addr  = {fetch_tag, fetch_idx, {OFF_W{1'b0}}};
  assign drain_addr  = {head_tag, head_idx, {OFF_W{1'b0}}};
  assign wr_accept   = mem_req_valid & mem_req_ready & mem_req_write;
  assign wb_quiet    = buf_empty & ~(mem_req_valid & mem_req_write) & acks_clear;

  wbb_store #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (evict_valid),
    .push_idx  (evict_idx),
    .push_tag  (evict_tag),
    .push_data (evict_data),
    .pop       (grant == GNT_DRAIN),
    .look_idx  (fetch_idx),
    .look_tag  (fetch_tag),
    .full      (buf_full),
    .empty     (buf_empty),
    .head_idx  (head_idx),
    .head_tag  (head_tag),
    .head_data (head_data),
    .look_hit  (look_hit),
    .look_data (look_data)
  );

  wbb_arb #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
  ) arb_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_want    (fetch_want),
    .fetch_addr    (fetch_addr),
    .drain_avail   (~buf_empty),
    .drain_addr    (drain_addr),
    .drain_data    (head_data),
    .mem_req_ready (mem_req_ready),
    .grant         (grant),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_len   (mem_req_len),
    .mem_req_wdata (mem_req_wdata)
  );

  wbb_resp #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .LINE_W(LINE_W), .ACK_W(ACK_W)
  ) resp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fwd_take   (fwd_take),
    .fwd_idx    (fetch_idx),
    .fwd_tag    (fetch_tag),
    .fwd_data   (look_data),
    .rsp_valid  (mem_rsp_valid),
    .rsp_write  (mem_rsp_write),
    .rsp_addr   (mem_rsp_addr),
    .rsp_data   (mem_rsp_data),
    .wr_accept  (wr_accept),
    .fill_valid (fill_valid),
    .fill_fwd   (fill_fwd),
    .fill_idx   (fill_idx),
    .fill_tag   (fill_tag),
    .fill_data  (fill_data),
    .acks_clear (acks_clear)
  );
endmodule

// File: rtl/wbb_chk.sv
module wbb_chk #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int OFF_W  = 3,
  parameter int ADDR_W = 15,
  parameter int LINE_W = 64,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evict_ready,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [IDX_W-1:0]  fetch_idx,
  input logic [TAG_W-1:0]  fetch_tag,
  input logic              look_hit,
  input logic              fill_valid,
  input logic              fill_fwd,
  input logic [IDX_W-1:0]  fill_idx,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [LEN_W-1:0]  mem_req_len,
  input logic [LINE_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_write,
  input logic              wb_quiet
);
  // R2
  line_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_len == LEN_W'(1 << OFF_W)) && (mem_req_addr[OFF_W-1:0] == '0));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R5
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R7
  fetch_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && !look_hit) |=> mem_req_valid && !mem_req_write
      && (mem_req_addr == $past({fetch_tag, fetch_idx, {OFF_W{1'b0}}})));

  // R8
  fwd_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && look_hit) |=> fill_valid && fill_fwd
      && (fill_idx == $past(fetch_idx)));

  // R11
  rsp_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !mem_rsp_write) |=> fill_valid && !fill_fwd);

  // R12
  quiet_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_ready |-> !wb_quiet);
endmodule

bind wb_forward_buffer wbb_chk #(
  .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W),
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .LEN_W(LEN_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .evict_ready   (evict_ready),
  .fetch_valid   (fetch_valid),
  .fetch_ready   (fetch_ready),
  .fetch_idx     (fetch_idx),
  .fetch_tag     (fetch_tag),
  .look_hit      (look_hit),
  .fill_valid    (fill_valid),
  .fill_fwd      (fill_fwd),
  .fill_idx      (fill_idx),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_len   (mem_req_len),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_write (mem_rsp_write),
  .wb_quiet      (wb_quiet)
);

// File: tb/wb_forward_buffer_tb.sv
module wb_forward_buffer_tb_top;
  localparam int IDX_W = 4, TAG_W = 8, OFF_W = 3, DEPTH = 4;
  localparam int LINE_W = 64, ADDR_W = 15, LEN_W = 4;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [LINE_W-1:0] data;
  } req_t;
  typedef struct packed {
    logic              fwd;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [LINE_W-1:0] data;
  } fill_t;

  logic clk, rst_n;
  logic evict_valid, evict_ready, fetch_valid, fetch_ready;
  logic [IDX_W-1:0] evict_idx, fetch_idx, fill_idx;
  logic [TAG_W-1:0] evict_tag, fetch_tag, fill_tag;
  logic [LINE_W-1:0] evict_data, fill_data, mem_req_wdata, mem_rsp_data;
  logic fill_valid, fill_fwd, mem_req_valid, mem_req_ready, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr, mem_rsp_addr;
  logic [LEN_W-1:0] mem_req_len;
  logic mem_rsp_valid, mem_rsp_write, wb_quiet;

  int n_chk = 0, n_bad = 0;
  req_t  exp_req[$];
  fill_t exp_fill[$];
  req_t  rsp_q[$];
  logic  prev_hs = 1'b0, prev_stall = 1'b0;
  req_t  stall_req;

  wb_forward_buffer #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_idx(evict_idx),
    .evict_tag(evict_tag), .evict_data(evict_data),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_idx(fetch_idx),
    .fetch_tag(fetch_tag),
    .fill_valid(fill_valid), .fill_fwd(fill_fwd), .fill_idx(fill_idx),
    .fill_tag(fill_tag), .fill_data(fill_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_len(mem_req_len), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_write(mem_rsp_write),
    .mem_rsp_addr(mem_rsp_addr), .mem_rsp_data(mem_rsp_data),
    .wb_quiet(wb_quiet)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [ADDR_W-1:0] line_addr(logic [IDX_W-1:0] i, logic [TAG_W-1:0] t);
    return {t, i, 3'b000};
  endfunction

  function automatic logic [LINE_W-1:0] mem_pattern(logic [ADDR_W-1:0] a);
    return {48'hFEED_0000_BEEF, 16'(a)};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      req_t  e;
      fill_t f;
      if (prev_hs) check(!mem_req_valid, "R5 idle cycle after accept", 64'(mem_req_valid), 64'd0);
      if (prev_stall) begin
        check(mem_req_valid && mem_req_write == stall_req.wr && mem_req_addr == stall_req.addr
              && mem_req_wdata == stall_req.data, "R4 payload held",
              64'(mem_req_addr), 64'(stall_req.addr));
      end
      prev_stall = mem_req_valid && !mem_req_ready;
      stall_req  = '{wr: mem_req_write, addr: mem_req_addr, data: mem_req_wdata};
      prev_hs    = mem_req_valid && mem_req_ready;
      if (mem_req_valid && mem_req_ready) begin
        if (exp_req.size() == 0) begin
          check(1'b0, "R2 R8 unexpected request", 64'(mem_req_addr), 64'd0);
        end else begin
          e = exp_req.pop_front();
          check(mem_req_write == e.wr && mem_req_addr == e.addr,
                e.wr ? "R2 R6 R10 write order/address" : "R6 R7 read address",
                64'({mem_req_write, mem_req_addr}), 64'({e.wr, e.addr}));
          if (e.wr) check(mem_req_wdata == e.data, "R2 R10 write data", mem_req_wdata, e.data);
          check(mem_req_len == LEN_W'(8), "R2 R7 line length", 64'(mem_req_len), 64'd8);
        end
        rsp_q.push_back('{wr: mem_req_write, addr: mem_req_addr, data: '0});
      end
      if (fill_valid) begin
        if (exp_fill.size() == 0) begin
          check(1'b0, "R8 R11 unexpected fill", fill_data, 64'd0);
        end else begin
          f = exp_fill.pop_front();
          check(fill_fwd == f.fwd && fill_idx == f.idx && fill_tag == f.tag && fill_data == f.data,
                f.fwd ? "R8 R9 forwarded fill" : "R11 memory fill", fill_data, f.data);
        end
      end
    end
  end

  // Memory responder: answers each accepted request on the next cycle.
  initial begin
    req_t r;
    mem_rsp_valid = 1'b0; mem_rsp_write = 1'b0; mem_rsp_addr = '0; mem_rsp_data = '0;
    forever begin
      @(posedge clk); #1;
      if (rsp_q.size() > 0) begin
        r = rsp_q.pop_front();
        mem_rsp_valid = 1'b1;
        mem_rsp_write = r.wr;
        mem_rsp_addr  = r.addr;
        mem_rsp_data  = r.wr ? '0 : mem_pattern(r.addr);
        if (!r.wr) exp_fill.push_back('{fwd: 1'b0, idx: r.addr[OFF_W +: IDX_W],
                                        tag: r.addr[OFF_W+IDX_W +: TAG_W], data: mem_pattern(r.addr)});
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic push_wr(input logic [IDX_W-1:0] i, input logic [TAG_W-1:0] t, input logic [LINE_W-1:0] d);
    exp_req.push_back('{wr: 1'b1, addr: line_addr(i, t), data: d});
  endtask

  task automatic push_rd(input logic [IDX_W-1:0] i, input logic [TAG_W-1:0] t);
    exp_req.push_back('{wr: 1'b0, addr: line_addr(i, t), data: '0});
  endtask

  // Drivers start and end at posedge + 1.
  task automatic evict(input logic [IDX_W-1:0] i, input logic [TAG_W-1:0] t,
                       input logic [LINE_W-1:0] d, input logic expect_take);
    evict_valid = 1'b1; evict_idx = i; evict_tag = t; evict_data = d;
    @(negedge clk);
    check(evict_ready == expect_take, "R3 eviction acceptance", 64'(evict_ready), 64'(expect_take));
    @(posedge clk); #1;
    evict_valid = 1'b0;
  endtask

  task automatic fetch(input logic [IDX_W-1:0] i, input logic [TAG_W-1:0] t, output int waited);
    logic took = 1'b0;
    waited = 0;
    fetch_valid = 1'b1; fetch_idx = i; fetch_tag = t;
    while (!took) begin
      @(negedge clk);
      if (fetch_ready) took = 1'b1;
      else waited++;
      @(posedge clk); #1;
    end
    fetch_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w;
    rst_n = 1'b0; evict_valid = 1'b0; fetch_valid = 1'b0; mem_req_ready = 1'b0;
    evict_idx = '0; evict_tag = '0; evict_data = '0; fetch_idx = '0; fetch_tag = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(!mem_req_valid, "R1 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    check(!fill_valid, "R1 fill_valid in reset", 64'(fill_valid), 64'd0);
    check(evict_ready, "R1 evict_ready in reset", 64'(evict_ready), 64'd1);
    check(wb_quiet, "R1 wb_quiet in reset", 64'(wb_quiet), 64'd1);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;

    // R2: plain drain in FIFO order, memory always ready
    mem_req_ready = 1'b1;
    push_wr(4'd1, 8'h10, 64'hAAAA_0000_0000_0001);
    push_wr(4'd2, 8'h11, 64'hAAAA_0000_0000_0002);
    push_wr(4'd1, 8'h12, 64'hAAAA_0000_0000_0003);
    evict(4'd1, 8'h10, 64'hAAAA_0000_0000_0001, 1'b1);
    evict(4'd2, 8'h11, 64'hAAAA_0000_0000_0002, 1'b1);
    evict(4'd1, 8'h12, 64'hAAAA_0000_0000_0003, 1'b1);
    @(negedge clk);
    check(!wb_quiet, "R12 busy while lines pending", 64'(wb_quiet), 64'd0);
    repeat (30) @(posedge clk); #1;
    @(negedge clk);
    check(wb_quiet, "R12 quiet after all acks", 64'(wb_quiet), 64'd1);
    @(posedge clk); #1;

    // R7 R11: fetch miss on an idle port
    push_rd(4'd2, 8'h20);
    fetch(4'd2, 8'h20, w);
    check(w == 0, "R7 miss taken at once on idle port", 64'(w), 64'd0);
    repeat (6) @(posedge clk); #1;

    // R3 R8 R9: fill up with memory stalled, duplicate line 5/0x50
    mem_req_ready = 1'b0;
    push_wr(4'd3, 8'h30, 64'hBBBB_0000_0000_0001);
    push_rd(4'd7, 8'h70);
    push_wr(4'd4, 8'h40, 64'hBBBB_0000_0000_0002);
    push_wr(4'd5, 8'h50, 64'hBBBB_0000_0000_00A0);
    push_wr(4'd6, 8'h60, 64'hBBBB_0000_0000_0004);
    push_wr(4'd5, 8'h50, 64'hBBBB_0000_0000_00B0);
    evict(4'd3, 8'h30, 64'hBBBB_0000_0000_0001, 1'b1);
    evict(4'd4, 8'h40, 64'hBBBB_0000_0000_0002, 1'b1);
    evict(4'd5, 8'h50, 64'hBBBB_0000_0000_00A0, 1'b1);
    evict(4'd6, 8'h60, 64'hBBBB_0000_0000_0004, 1'b1);
    evict(4'd5, 8'h50, 64'hBBBB_0000_0000_00B0, 1'b1);
    // R3: buffer full, this one is dropped (no write expected for it)
    evict(4'd9, 8'h99, 64'hDEAD_DEAD_DEAD_DEAD, 1'b0);
    @(negedge clk);
    check(!wb_quiet, "R12 not quiet while full", 64'(wb_quiet), 64'd0);
    @(posedge clk); #1;
    // R8 R9: forward hit while the slot is stalled, newest copy wins
    exp_fill.push_back('{fwd: 1'b1, idx: 4'd5, tag: 8'h50, data: 64'hBBBB_0000_0000_00B0});
    fetch(4'd5, 8'h50, w);
    check(w == 0, "R8 hit taken while slot busy", 64'(w), 64'd0);

    // R6 R7: miss waits for the slot, then beats the buffered writebacks
    fork
      fetch(4'd7, 8'h70, w);
      begin
        repeat (3) @(posedge clk); #1;
        mem_req_ready = 1'b1;
      end
    join
    check(w > 0, "R7 miss held while slot busy", 64'(w), 64'd1);
    repeat (40) @(posedge clk); #1;
    @(negedge clk);
    check(wb_quiet, "R10 R12 all lines drained and acked", 64'(wb_quiet), 64'd1);
    check(exp_req.size() == 0, "R2 R10 all expected requests seen", 64'(exp_req.size()), 64'd0);
    check(exp_fill.size() == 0, "R8 R11 all expected fills seen", 64'(exp_fill.size()), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule